// File: doc/BRIEF.md
# Three-Level Manchester Half-Bit Detector

This block sits behind the two threshold comparators of a bi-phase serial bus receiver. It is clocked by a local sample clock that runs at twelve times the bit rate and has no phase relation to the incoming data. On every clock it classifies the comparator pair into one of three levels: positive, negative or dead zone. It then decides which runs of samples form genuine half bits.

A half bit is accepted only when a qualifying sample is followed by two samples that are not of the opposite polarity. If the opposite level shows up in either confirming slot, the candidate is dropped and the search starts again from that sample. After each accepted half bit, a short hold-off prevents a single nominal half bit from being reported twice.

A small assembler pairs the half bits into data bits. A positive half followed by a negative half gives a one, and the reverse order gives a zero. Two halves of the same polarity in a row raise an error pulse, and the newer half becomes the start of the next pair. If the second half of a pair does not arrive in time, the pending half is discarded and a timeout pulse is raised.

Top module: `halfbit_detector`

## Requirements
- R1: While reset is asserted and on the first clock after it, every output (`hb_valid`, `hb_pos`, `bit_valid`, `bit_value`, `bit_err`, `idle_timeout`) is low.
- R2: After `SYNC_STAGES` register stages, a sample is classified as follows: positive when only `above_pos` is high, negative when only `below_neg` is high, dead zone otherwise. A sample with both flags high is treated as dead zone and never starts a candidate.
- R3: A positive sample followed by two samples that are each positive or dead zone produces exactly one `hb_valid` pulse with `hb_pos` = 1.
- R4: A negative sample followed by two samples that are each negative or dead zone produces exactly one `hb_valid` pulse with `hb_pos` = 0.
- R5: A sample of the opposite level in either confirming slot erases the candidate. That same sample then starts a new candidate of its own polarity.
- R6: The `HOLD_SAMPLES` samples (default 3) that follow the third sample of an accepted half bit are ignored. Strobes are therefore at least `HOLD_SAMPLES`+3 clocks apart. An unbroken run of 12 samples at one level yields exactly two half bits, and a run of 6 yields one.
- R7: A positive half followed by a negative half gives `bit_value` = 1. A negative half followed by a positive half gives 0. `bit_valid` is a one-clock pulse on the clock after the second half's strobe.
- R8: A half bit of the same polarity as the pending first half pulses `bit_err` for one clock instead of producing a bit. The new half then becomes the first half of the next pair.
- R9: While a first half is pending, the 25th consecutive clock without a strobe (more than `IDLE_LIMIT` = 24) pulses `idle_timeout` for one clock and drops the pending half. The next half bit then starts a new pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, twelve times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| above_pos | input | 1 | Comparator flag: signal above the positive threshold |
| below_neg | input | 1 | Comparator flag: signal below the negative threshold |
| hb_valid | output | 1 | One-clock strobe for an accepted half bit |
| hb_pos | output | 1 | Polarity of the last accepted half bit (1 = positive) |
| bit_valid | output | 1 | One-clock strobe for an assembled data bit |
| bit_value | output | 1 | Value of the assembled bit, valid with `bit_valid` |
| bit_err | output | 1 | One-clock pulse on two same-polarity half bits in a row |
| idle_timeout | output | 1 | One-clock pulse when a pending half bit expires |

## Verification
The half-bit assertions assume that the comparator flags hold their value for whole clock periods, so that the classified level seen at the end of the synchronizer stands for one sample. The bench changes the flags only on the falling clock edge, one sample per clock, with no glitches. The spacing assertion assumes that the hold-off is at least one sample, which the default parameters satisfy. The stimulus uses exact 6-sample halves, halves shortened by a dead-zone sample at each transition, single-sample spikes and widened halves. This keeps every pattern inside the sampling model that the requirements describe.

// File: rtl/halfbit_detector.sv
module halfbit_detector #(
  parameter int SYNC_STAGES  = 2,
  parameter int HOLD_SAMPLES = 3,
  parameter int IDLE_LIMIT   = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic above_pos,
  input  logic below_neg,
  output logic hb_valid,
  output logic hb_pos,
  output logic bit_valid,
  output logic bit_value,
  output logic bit_err,
  output logic idle_timeout
);
  localparam int HW     = $clog2(HOLD_SAMPLES + 1);
  localparam int IW     = $clog2(IDLE_LIMIT + 1);
  localparam int GAP    = HOLD_SAMPLES + 3;
  localparam int GW     = $clog2(GAP + 1);

  typedef enum logic [1:0] {SEEK, CAND, HOLD} seek_st_t;

  logic [SYNC_STAGES-1:0] pos_sh, neg_sh;
  logic lvl_pos, lvl_neg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pos_sh <= '0;
      neg_sh <= '0;
    end else begin
      pos_sh <= {pos_sh[SYNC_STAGES-2:0], above_pos};
      neg_sh <= {neg_sh[SYNC_STAGES-2:0], below_neg};
    end

  assign lvl_pos = pos_sh[SYNC_STAGES-1] & ~neg_sh[SYNC_STAGES-1];
  assign lvl_neg = neg_sh[SYNC_STAGES-1] & ~pos_sh[SYNC_STAGES-1];

  seek_st_t st;
  logic cand_pos, conf_seen;
  logic [HW-1:0] hold_cnt;
  logic opposite;

  assign opposite = cand_pos ? lvl_neg : lvl_pos;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st        <= SEEK;
      cand_pos  <= 1'b0;
      conf_seen <= 1'b0;
      hold_cnt  <= '0;
      hb_valid  <= 1'b0;
      hb_pos    <= 1'b0;
    end else begin
      hb_valid <= 1'b0;
      unique case (st)
        SEEK:
          if (lvl_pos || lvl_neg) begin
            st        <= CAND;
            cand_pos  <= lvl_pos;
            conf_seen <= 1'b0;
          end
        CAND:
          if (opposite) begin
            cand_pos  <= lvl_pos;
            conf_seen <= 1'b0;
          end else if (conf_seen) begin
            hb_valid <= 1'b1;
            hb_pos   <= cand_pos;
            hold_cnt <= HW'(HOLD_SAMPLES - 1);
            st       <= HOLD;
          end else begin
            conf_seen <= 1'b1;
          end
        HOLD:
          if (hold_cnt == '0) st <= SEEK;
          else hold_cnt <= hold_cnt - 1'b1;
        default: st <= SEEK;
      endcase
    end

  logic have_first, first_pos;
  logic [IW-1:0] idle_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      have_first   <= 1'b0;
      first_pos    <= 1'b0;
      idle_cnt     <= '0;
      bit_valid    <= 1'b0;
      bit_value    <= 1'b0;
      bit_err      <= 1'b0;
      idle_timeout <= 1'b0;
    end else begin
      bit_valid    <= 1'b0;
      bit_err      <= 1'b0;
      idle_timeout <= 1'b0;
      if (hb_valid) begin
        idle_cnt <= '0;
        if (!have_first) begin
          have_first <= 1'b1;
          first_pos  <= hb_pos;
        end else if (hb_pos != first_pos) begin
          bit_valid  <= 1'b1;
          bit_value  <= first_pos;
          have_first <= 1'b0;
        end else begin
          bit_err   <= 1'b1;
          first_pos <= hb_pos;
        end
      end else if (have_first) begin
        if (idle_cnt == IW'(IDLE_LIMIT)) begin
          idle_timeout <= 1'b1;
          have_first   <= 1'b0;
          idle_cnt     <= '0;
        end else begin
          idle_cnt <= idle_cnt + 1'b1;
        end
      end
    end

  logic [GW-1:0] since_hb;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) since_hb <= GW'(GAP);
    else if (hb_valid) since_hb <= '0;
    else if (since_hb != GW'(GAP)) since_hb <= since_hb + 1'b1;

  assert_pos_confirm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hb_valid && hb_pos) |-> ($past(lvl_pos, 3) && !$past(lvl_neg, 2) && !$past(lvl_neg, 1)));

  assert_neg_confirm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hb_valid && !hb_pos) |-> ($past(lvl_neg, 3) && !$past(lvl_pos, 2) && !$past(lvl_pos, 1)));

  assert_both_dead_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hb_valid |-> !($past(pos_sh[SYNC_STAGES-1], 3) && $past(neg_sh[SYNC_STAGES-1], 3)));

  assert_hold_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hb_valid |-> (since_hb >= GW'(GAP - 1)));

  assert_bit_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> ($past(hb_valid) && (bit_value == !$past(hb_pos))));

  assert_err_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bit_err |-> ($past(hb_valid) && !bit_valid));

  assert_timeout_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    idle_timeout |-> (!$past(hb_valid) && $onehot0({idle_timeout, bit_valid, bit_err})));
endmodule

// File: tb/halfbit_detector_tb.sv
module halfbit_detector_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic above_pos = 1'b0;
  logic below_neg = 1'b0;
  logic hb_valid, hb_pos, bit_valid, bit_value, bit_err, idle_timeout;

  halfbit_detector dut_i (
    .clk(clk), .rst_n(rst_n), .above_pos(above_pos), .below_neg(below_neg),
    .hb_valid(hb_valid), .hb_pos(hb_pos), .bit_valid(bit_valid),
    .bit_value(bit_value), .bit_err(bit_err), .idle_timeout(idle_timeout)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_hb = 0, n_hbp = 0, n_bit = 0, n_err = 0, n_to = 0;
  logic [31:0] bit_hist = '0;

  always @(negedge clk)
    if (rst_n) begin
      if (hb_valid) n_hb++;
      if (hb_valid && hb_pos) n_hbp++;
      if (bit_valid) begin
        n_bit++;
        bit_hist = {bit_hist[30:0], bit_value};
      end
      if (bit_err) n_err++;
      if (idle_timeout) n_to++;
    end

  int checks = 0, errors = 0;
  int b_hb, b_hbp, b_bit, b_err, b_to;

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic put(input bit p, input bit n);
    @(negedge clk);
    above_pos = p;
    below_neg = n;
  endtask

  task automatic idle(input int k);
    repeat (k) put(1'b0, 1'b0);
  endtask

  task automatic half(input bit pos, input int k);
    repeat (k) put(pos, !pos);
  endtask

  task automatic restart();
    @(negedge clk);
    rst_n = 1'b0;
    above_pos = 1'b0;
    below_neg = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    b_hb = n_hb; b_hbp = n_hbp; b_bit = n_bit; b_err = n_err; b_to = n_to;
  endtask

  task automatic test_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 outputs in reset",
          int'({hb_valid, hb_pos, bit_valid, bit_value, bit_err, idle_timeout}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 outputs after reset",
          int'({hb_valid, hb_pos, bit_valid, bit_value, bit_err, idle_timeout}), 0);
  endtask

  task automatic test_positive();
    restart();
    half(1'b1, 6); idle(10);
    check("R3 one positive half", n_hb - b_hb, 1);
    check("R3 polarity positive", n_hbp - b_hbp, 1);
    check("R6 six-sample run gives one", n_bit - b_bit, 0);
    restart();
    put(1, 0); put(0, 0); put(0, 0); idle(10);
    check("R3 dead-zone confirms", n_hbp - b_hbp, 1);
  endtask

  task automatic test_dead_zone();
    restart();
    repeat (8) put(1, 1);
    idle(8);
    check("R2 both flags never start", n_hb - b_hb, 0);
    restart();
    put(1, 0); put(1, 1); put(1, 1); idle(10);
    check("R2 both flags confirm as dead zone", n_hbp - b_hbp, 1);
  endtask

  task automatic test_negative();
    restart();
    half(1'b0, 6); idle(10);
    check("R4 one negative half", n_hb - b_hb, 1);
    check("R4 polarity negative", n_hbp - b_hbp, 0);
  endtask

  task automatic test_erase();
    restart();
    put(1, 0); put(0, 0); put(0, 1); put(0, 0); put(0, 0); idle(10);
    check("R5 erase in third slot count", n_hb - b_hb, 1);
    check("R5 erase in third slot restarts negative", n_hbp - b_hbp, 0);
    restart();
    put(1, 0); put(0, 1); put(0, 0); put(0, 0); idle(10);
    check("R5 erase in second slot count", n_hb - b_hb, 1);
    check("R5 erase in second slot restarts negative", n_hbp - b_hbp, 0);
    restart();
    put(0, 1); put(1, 0); put(0, 0); put(0, 0); idle(10);
    check("R5 mirror erase restarts positive", n_hbp - b_hbp, 1);
  endtask

  task automatic test_word();
    restart();
    half(1, 6); half(0, 6);
    half(0, 6); half(1, 6);
    half(1, 6); half(0, 6);
    half(1, 6); half(0, 6);
    half(0, 6); half(1, 6);
    half(0, 6); half(1, 6);
    idle(10);
    check("R6 twelve-sample runs split", n_hb - b_hb, 12);
    check("R7 bit count", n_bit - b_bit, 6);
    check("R7 bit values 101100", int'(bit_hist[5:0]), 6'b101100);
    check("R8 no error in clean word", n_err - b_err, 0);
    check("R9 no timeout in clean word", n_to - b_to, 0);
    restart();
    half(0, 5); put(0, 0); half(1, 5); put(0, 0);
    half(1, 5); put(0, 0); half(0, 5); put(0, 0);
    half(1, 5); put(0, 0); half(0, 5); put(0, 0);
    idle(10);
    check("R7 shifted phase bit count", n_bit - b_bit, 3);
    check("R7 shifted phase values 011", int'(bit_hist[2:0]), 3'b011);
  endtask

  task automatic test_extra();
    restart();
    half(1, 9); half(0, 6); idle(10);
    check("R6 widened half gives extra", n_hb - b_hb, 3);
    check("R8 error on same polarity", n_err - b_err, 1);
    check("R8 realigned pair count", n_bit - b_bit, 1);
    check("R8 realigned pair value", int'(bit_hist[0]), 1);
  endtask

  task automatic test_spike();
    restart();
    put(1, 0); put(0, 1); half(1, 4); half(0, 6); idle(10);
    check("R5 spike erased then recovered", n_hb - b_hb, 2);
    check("R5 spike no error", n_err - b_err, 0);
    check("R7 spike bit value", int'(bit_hist[0]), 1);
    check("R7 spike bit count", n_bit - b_bit, 1);
  endtask

  task automatic test_timeout();
    restart();
    half(1, 6); idle(15);
    check("R9 no early timeout", n_to - b_to, 0);
    idle(25);
    check("R9 timeout fires", n_to - b_to, 1);
    half(0, 6); idle(10);
    check("R9 fresh pair after timeout bits", n_bit - b_bit, 0);
    check("R9 fresh pair after timeout errors", n_err - b_err, 0);
    idle(30);
    check("R9 second timeout", n_to - b_to, 2);
  endtask

  bit timed_out = 1'b0;

  initial begin
    fork
      begin
        test_reset();
        test_positive();
        test_dead_zone();
        test_negative();
        test_erase();
        test_word();
        test_extra();
        test_spike();
        test_timeout();
      end
      begin
        repeat (100000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    if (timed_out) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule